// File: doc/BRIEF.md
# Station Link Weight Table with Request-to-Send Lookup

This block sits on the MAC side of a multi-antenna wireless modem. The baseband has no memory of its own for link weights, so this block keeps them. It holds a small table of known stations. Each entry pairs a 48-bit station address with the receive weights last found best for the link to that station: four 16-bit I/Q values, packed as one 64-bit word.

Every regular data frame is preceded by a request-to-send frame. When such a frame arrives, its transmitter address is compared against all entries in parallel. On a hit, the stored weights go to the weight-delivery output. On a miss, a default weight word goes out instead, and a flag asks software to start a training exchange with that station. Both cases complete one cycle after the request-to-send strobe, well before the data frame begins.

The block also decides whether a clear-to-send reply is due. That is only the case for a unicast request addressed to this station. Group-addressed frames are preceded by a lone request-to-send and get no reply. Optimal weights reported after a training exchange are written into the table: they overwrite the peer's existing entry, fill a free slot, or replace the least recently used entry when the table is full. A legacy mode forces default weights and suppresses both the reply and the training flag, for operation with access points that know nothing of this scheme.

Top module: `link_weight_table`

## Requirements
- R1: After reset `wgt_load`, `cts_req`, `train_req` are 0 and `wgt_out` is zero, and the table is empty so the first lookup of any address misses.
- R2: A strobe on `rts_valid` (with `legacy_mode` low) whose `rts_ta` matches a stored station gives, on the next cycle, a one-cycle `wgt_load` pulse with `wgt_out` equal to that station's stored weights.
- R3: A lookup (with `legacy_mode` low) that matches no stored station gives, on the next cycle, `wgt_load` with `wgt_out` equal to `dflt_wgt` and a one-cycle `train_req` pulse.
- R4: `cts_req` pulses on the cycle after the strobe only when `legacy_mode` is low, bit 40 of `rts_ra` (the group bit, the least significant bit of the first address octet held in bits 47:40) is 0, and `rts_ra` equals `own_addr`. This does not depend on whether the lookup hits.
- R5: With `legacy_mode` high, a strobe loads `dflt_wgt` even for a stored station, and raises neither `cts_req` nor `train_req`. Such a lookup also does not count as a use for replacement.
- R6: An update (`upd_valid`) for an address already in the table replaces that entry's weights without taking a new slot. A later lookup returns the new weights, and every other stored station remains.
- R7: Updates for up to `ENTRIES` (8) distinct addresses are all kept, and each one can then be looked up with its own weights.
- R8: An update for a new address while the table is full evicts the station whose last use lies furthest back. A use is a hit lookup or an update. Only that station misses afterwards.
- R9: When a lookup and an update fall in the same cycle, the lookup returns the table contents from before the update. For replacement, the lookup's use counts before the update's. The update is visible to the next lookup.
- R10: Between loads `wgt_out` holds the last loaded value and `wgt_load` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_mode | input | 1 | Forces default weights, no reply request, no training flag |
| own_addr | input | 48 | This station's address |
| dflt_wgt | input | 64 | Default weight word used on a miss or in legacy mode |
| rts_valid | input | 1 | One-cycle strobe: request-to-send addresses are valid |
| rts_ta | input | 48 | Transmitter address of the request-to-send |
| rts_ra | input | 48 | Receiver address of the request-to-send; bit 40 is the group bit |
| upd_valid | input | 1 | One-cycle strobe: new optimal weights for a peer |
| upd_addr | input | 48 | Peer address for the weight update |
| upd_wgt | input | 64 | New weights, four 16-bit I/Q values |
| wgt_load | output | 1 | One-cycle pulse: `wgt_out` has just been loaded |
| wgt_out | output | 64 | Weights toward the weight-delivery path |
| cts_req | output | 1 | One-cycle pulse: a clear-to-send reply is needed |
| train_req | output | 1 | One-cycle pulse: the sender is unknown, training is needed |

## Verification
A request-to-send lookup and a training update can land in the same cycle, sometimes for the same station and sometimes with the update evicting the very entry the lookup just touched. The bench provokes this on purpose with directed cases (same station already stored, same station new, and eviction of a station looked up in that cycle) and also inside a long pseudo-random sweep that mixes lone lookups, lone updates and paired operations over a pool of twelve stations. Each case is judged against a bench model that uses timestamps: the lookup result is taken from the state before the update, and the lookup's use is stamped before the update's, so the model predicts exactly which station must disappear.

// File: rtl/lwt_pkg.sv
package lwt_pkg;
  // Station addresses are 48 bits; the group bit is the LSB of the first
  // octet, which sits in bits 47:40.
  localparam int ADDR_W    = 48;
  localparam int GROUP_BIT = 40;

  function automatic logic is_group(input logic [ADDR_W-1:0] a);
    return a[GROUP_BIT];
  endfunction
endpackage

// File: rtl/lwt_store.sv
module lwt_store
  import lwt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int WV_W    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              look_en,
  input  logic [ADDR_W-1:0] look_addr,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [WV_W-1:0]   upd_wgt,
  output logic              look_hit,
  output logic [WV_W-1:0]   look_wgt
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);

  typedef logic [ENTRIES-1:0][IDX_W-1:0] age_vec_t;

  logic [ENTRIES-1:0]             vld_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] addr_q;
  logic [ENTRIES-1:0][WV_W-1:0]   wgt_q;
  age_vec_t                       age_q, age_look, age_next;

  logic [ENTRIES-1:0] look_match, upd_match, oldest_vec;
  logic [IDX_W-1:0]   look_idx, upd_idx, free_idx, lru_idx;
  logic               upd_hit, table_full;

  // Lowest set bit of a vector.
  function automatic logic [IDX_W-1:0] first_set(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int j = ENTRIES - 1; j >= 0; j--)
      if (v[j]) r = IDX_W'(j);
    return r;
  endfunction

  // Mark entry idx as most recently used; younger entries age by one.
  function automatic age_vec_t touch(input age_vec_t a, input logic [IDX_W-1:0] idx);
    age_vec_t r;
    for (int j = 0; j < ENTRIES; j++) begin
      if (IDX_W'(j) == idx)  r[j] = '0;
      else if (a[j] < a[idx]) r[j] = a[j] + 1'b1;
      else                   r[j] = a[j];
    end
    return r;
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign look_match[g] = vld_q[g] && (addr_q[g] == look_addr);
    assign upd_match[g]  = vld_q[g] && (addr_q[g] == upd_addr);
    assign oldest_vec[g] = (age_look[g] == AGE_MAX);
  end

  assign look_hit   = |look_match;
  assign look_idx   = first_set(look_match);
  assign look_wgt   = wgt_q[look_idx];
  assign table_full = &vld_q;
  assign free_idx   = first_set(~vld_q);
  assign lru_idx    = first_set(oldest_vec);
  assign upd_hit    = |upd_match;

  always_comb begin
    age_look = (look_en && look_hit) ? touch(age_q, look_idx) : age_q;
    if (upd_hit)         upd_idx = first_set(upd_match);
    else if (table_full) upd_idx = lru_idx;
    else                 upd_idx = free_idx;
    age_next = upd_en ? touch(age_look, upd_idx) : age_look;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      addr_q <= '0;
      wgt_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else begin
      age_q <= age_next;
      if (upd_en) begin
        vld_q[upd_idx]  <= 1'b1;
        addr_q[upd_idx] <= upd_addr;
        wgt_q[upd_idx]  <= upd_wgt;
      end
    end
  end

  // R7: stored addresses stay unique, so at most one entry ever matches.
  p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match));
  // R8: recency ranks stay a permutation, so exactly one entry is oldest.
  p_one_oldest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest_vec));
  // R6: an update for a stored address reuses its slot, occupancy unchanged.
  p_no_dup_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_hit) |=> $stable(vld_q));
endmodule

// File: rtl/lwt_rts_ctrl.sv
module lwt_rts_ctrl
  import lwt_pkg::*;
#(
  parameter int WV_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rts_valid,
  input  logic              legacy_mode,
  input  logic [ADDR_W-1:0] rts_ra,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              look_hit,
  input  logic [WV_W-1:0]   look_wgt,
  input  logic [WV_W-1:0]   dflt_wgt,
  output logic              wgt_load,
  output logic [WV_W-1:0]   wgt_out,
  output logic              cts_req,
  output logic              train_req
);
  function automatic logic [WV_W-1:0] pick_wgt(input logic legacy, input logic hit,
                                                input logic [WV_W-1:0] stored,
                                                input logic [WV_W-1:0] dflt);
    return (legacy || !hit) ? dflt : stored;
  endfunction

  logic reply_due, miss_seen;
  assign reply_due = !legacy_mode && !is_group(rts_ra) && (rts_ra == own_addr);
  assign miss_seen = !legacy_mode && !look_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wgt_load  <= 1'b0;
      wgt_out   <= '0;
      cts_req   <= 1'b0;
      train_req <= 1'b0;
    end else begin
      wgt_load  <= rts_valid;
      cts_req   <= rts_valid && reply_due;
      train_req <= rts_valid && miss_seen;
      if (rts_valid) wgt_out <= pick_wgt(legacy_mode, look_hit, look_wgt, dflt_wgt);
    end
  end

  p_load_follows_rts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rts_valid |=> wgt_load);
  p_train_with_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    train_req |-> wgt_load);
  p_cts_unicast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cts_req |-> $past(rts_valid && !legacy_mode && !rts_ra[GROUP_BIT]));
  p_legacy_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_valid && legacy_mode) |=> (!cts_req && !train_req && wgt_out == $past(dflt_wgt)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wgt_load |-> $stable(wgt_out));
endmodule

// File: rtl/link_weight_table.sv
module link_weight_table
  import lwt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int NWGT    = 4,
  parameter int WGT_W   = 16,
  localparam int WV_W   = NWGT * WGT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              legacy_mode,
  input  logic [47:0]       own_addr,
  input  logic [WV_W-1:0]   dflt_wgt,
  input  logic              rts_valid,
  input  logic [47:0]       rts_ta,
  input  logic [47:0]       rts_ra,
  input  logic              upd_valid,
  input  logic [47:0]       upd_addr,
  input  logic [WV_W-1:0]   upd_wgt,
  output logic              wgt_load,
  output logic [WV_W-1:0]   wgt_out,
  output logic              cts_req,
  output logic              train_req
);
  logic            look_en, look_hit;
  logic [WV_W-1:0] look_wgt;

  // Legacy operation leaves the table untouched by lookups.
  assign look_en = rts_valid && !legacy_mode;

  lwt_store #(.ENTRIES(ENTRIES), .WV_W(WV_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .look_en(look_en), .look_addr(rts_ta),
    .upd_en(upd_valid), .upd_addr(upd_addr), .upd_wgt(upd_wgt),
    .look_hit(look_hit), .look_wgt(look_wgt)
  );

  lwt_rts_ctrl #(.WV_W(WV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rts_valid(rts_valid), .legacy_mode(legacy_mode),
    .rts_ra(rts_ra), .own_addr(own_addr),
    .look_hit(look_hit), .look_wgt(look_wgt), .dflt_wgt(dflt_wgt),
    .wgt_load(wgt_load), .wgt_out(wgt_out),
    .cts_req(cts_req), .train_req(train_req)
  );

  // R9: the result of a same-cycle lookup comes from the old contents.
  p_same_cycle_old_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_valid && !legacy_mode && !look_hit && upd_valid && upd_addr == rts_ta)
      |=> (train_req && wgt_out == $past(dflt_wgt)));
endmodule

// File: tb/tb_link_weight_table.sv
module tb_link_weight_table;
  localparam int POOL = 12;
  localparam int CAP  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        legacy_mode = 1'b0;
  logic [47:0] own_addr = {8'h04, 8'h22, 16'h0000, 16'h0ABC};
  logic [63:0] dflt_wgt = 64'h4000_0000_4000_0000;
  logic        rts_valid = 1'b0;
  logic [47:0] rts_ta = '0, rts_ra = '0;
  logic        upd_valid = 1'b0;
  logic [47:0] upd_addr = '0;
  logic [63:0] upd_wgt = '0;
  logic        wgt_load, cts_req, train_req;
  logic [63:0] wgt_out;

  int checks = 0, errors = 0;
  bit done = 0;

  bit          in_tab[POOL];
  int          stamp[POOL];
  logic [63:0] mw[POOL];
  int          tnow = 0;

  always #10 clk = ~clk;

  link_weight_table dut (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .own_addr(own_addr),
    .dflt_wgt(dflt_wgt), .rts_valid(rts_valid), .rts_ta(rts_ta), .rts_ra(rts_ra),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_wgt(upd_wgt),
    .wgt_load(wgt_load), .wgt_out(wgt_out), .cts_req(cts_req), .train_req(train_req)
  );

  function automatic logic [47:0] addr_of(input int k);
    return {8'h02, 8'h11, 16'h0000, 16'(k) + 16'h0100};
  endfunction

  function automatic logic [63:0] w_of(input int s);
    return {16'(s * 7 + 1), 16'(s * 13 + 2), ~16'(s), 16'(s) ^ 16'h5A5A};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int count_tab();
    int c = 0;
    for (int i = 0; i < POOL; i++) if (in_tab[i]) c++;
    return c;
  endfunction

  function automatic void mdl_upd(input int k, input logic [63:0] w);
    if (!in_tab[k] && count_tab() == CAP) begin
      int v = -1;
      for (int i = 0; i < POOL; i++)
        if (in_tab[i] && (v < 0 || stamp[i] < stamp[v])) v = i;
      in_tab[v] = 0;
    end
    in_tab[k] = 1;
    mw[k] = w;
    tnow++;
    stamp[k] = tnow;
  endfunction

  // Lookup of pool station k (k < 0 means an unknown address), optional
  // simultaneous update of pool station uk with weights uw.
  task automatic op(input int k, input logic [47:0] ra, input bit leg,
                    input bit do_upd, input int uk, input logic [63:0] uw, input string req);
    bit hit;
    logic [63:0] ew;
    bit ects, etrain;
    rts_valid = 1'b1;
    rts_ta = (k < 0) ? 48'hAAAA_0000_0001 : addr_of(k);
    rts_ra = ra;
    legacy_mode = leg;
    upd_valid = do_upd;
    upd_addr = addr_of(uk);
    upd_wgt = uw;
    hit = (k >= 0) && in_tab[k];
    ew = (leg || !hit) ? dflt_wgt : mw[k];
    ects = !leg && !ra[40] && (ra == own_addr);
    etrain = !leg && !hit;
    if (!leg && hit) begin
      tnow++;
      stamp[k] = tnow;
    end
    if (do_upd) mdl_upd(uk, uw);
    @(posedge clk);
    @(negedge clk);
    rts_valid = 1'b0;
    upd_valid = 1'b0;
    legacy_mode = 1'b0;
    chk(wgt_load === 1'b1, {req, " wgt_load"}, 64'(wgt_load), 64'd1);
    chk(wgt_out === ew, {req, " wgt_out"}, wgt_out, ew);
    chk(cts_req === ects, {req, " cts_req"}, 64'(cts_req), 64'(ects));
    chk(train_req === etrain, {req, " train_req"}, 64'(train_req), 64'(etrain));
  endtask

  task automatic upd(input int k, input logic [63:0] w);
    upd_valid = 1'b1;
    upd_addr = addr_of(k);
    upd_wgt = w;
    mdl_upd(k, w);
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] other_ra;
    logic [63:0] held;
    int unsigned seed;
    other_ra = {8'h06, 8'h33, 32'h0000_1234};
    for (int i = 0; i < POOL; i++) begin
      in_tab[i] = 0;
      stamp[i] = 0;
      mw[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(wgt_load === 1'b0 && cts_req === 1'b0 && train_req === 1'b0, "R1 flags",
        {61'd0, wgt_load, cts_req, train_req}, 64'd0);
    chk(wgt_out === 64'd0, "R1 wgt_out", wgt_out, 64'd0);
    op(0, own_addr, 0, 0, 0, '0, "R1 R3 empty miss");

    // R7: fill the table, every station retrievable; R4 reply decision
    for (int i = 0; i < CAP; i++) upd(i, w_of(i + 1));
    for (int i = 0; i < CAP; i++) op(i, (i % 2 == 0) ? own_addr : other_ra, 0, 0, 0, '0, "R7 R2 R4 fill");
    op(3, own_addr | (48'd1 << 40), 0, 0, 0, '0, "R4 group ra");
    op(-1, own_addr, 0, 0, 0, '0, "R4 R3 miss unicast");

    // R6: overwrite existing station
    upd(3, w_of(99));
    for (int i = 0; i < CAP; i++) op(i, other_ra, 0, 0, 0, '0, "R6 overwrite");

    // R8: full table eviction, station 2 made oldest by touching the rest
    for (int i = 0; i < CAP; i++) if (i != 2) op(i, other_ra, 0, 0, 0, '0, "R8 touch");
    upd(8, w_of(50));
    op(2, other_ra, 0, 0, 0, '0, "R8 evicted");
    op(8, other_ra, 0, 0, 0, '0, "R8 newcomer");

    // R5: legacy mode on a stored station
    op(8, own_addr, 1, 0, 0, '0, "R5 legacy");
    op(-1, own_addr, 1, 0, 0, '0, "R5 legacy unknown");

    // R10: hold between loads
    op(4, other_ra, 0, 0, 0, '0, "R10 load");
    held = wgt_out;
    repeat (3) @(negedge clk);
    chk(wgt_out === held && wgt_load === 1'b0, "R10 hold", wgt_out, held);

    // R9: same-cycle lookup and update
    op(4, other_ra, 0, 1, 4, w_of(77), "R9 same stored");
    op(4, other_ra, 0, 0, 0, '0, "R9 visible");
    op(9, own_addr, 0, 1, 9, w_of(88), "R9 same new");
    op(9, own_addr, 0, 0, 0, '0, "R9 new visible");
    begin
      int oldest = -1;
      for (int i = 0; i < POOL; i++)
        if (in_tab[i] && (oldest < 0 || stamp[i] < stamp[oldest])) oldest = i;
      op(oldest, other_ra, 0, 1, 10, w_of(66), "R9 R8 touch then evict");
    end
    for (int i = 0; i < POOL; i++) op(i, other_ra, 0, 0, 0, '0, "R9 R8 after");

    // Sweep: mixed lookups, updates and paired operations
    seed = 32'h1234_5678;
    for (int n = 0; n < 600; n++) begin
      int kind, ka, kb;
      seed = seed * 32'd1103515245 + 32'd12345;
      kind = int'(seed[31:29]);
      ka = int'(seed[27:16]) % POOL;
      kb = int'(seed[15:4]) % POOL;
      if (kind < 3)      upd(kb, w_of(n + 200));
      else if (kind < 6) op(ka, (seed[2]) ? own_addr : other_ra, 0, 0, 0, '0, "R2 R3 R8 sweep");
      else if (kind < 7) op(ka, own_addr, 0, 1, kb, w_of(n + 900), "R9 sweep pair");
      else               op(ka, own_addr, 1, 0, 0, '0, "R5 sweep legacy");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule